// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Target

This block lets programmable logic stand in for a 16-bit asynchronous static RAM on a board bus. An external master drives active-low select, write strobe, output enable and two byte-lane enables, plus an address and a data word. A fast internal clock oversamples all of them. Each sampled pin state is decoded into one of four bus modes. Reads are served from an on-chip memory whose depth is a parameter. A write is committed when the master ends its write pulse.

The data bus is split into a lower lane (bits 7:0) and an upper lane (bits 15:8). Each lane has its own drive enable and its own write gating. The surrounding pad logic turns `dq_out` and `dq_drive` into tri-state buffers. The block also reports the decoded mode on `bus_mode`, so the rest of the chip can follow bus activity.

Top module: `sram_pin_target`

## Requirements
- R1: Standby (`bus_mode` = 0) applies when `chip_sel_n` is high, or when `hi_byte_n` and `lo_byte_n` are both high. In standby, `dq_drive` is 00.
- R2: With `chip_sel_n` low, `wr_strobe_n` high, `out_en_n` high and at least one lane enable low, the mode is output-off (`bus_mode` = 1) and `dq_drive` is 00.
- R3: With `chip_sel_n` low, `out_en_n` low, `wr_strobe_n` high and at least one lane enable low, the mode is read (`bus_mode` = 2). `dq_drive[0]` follows `lo_byte_n` low, and `dq_drive[1]` follows `hi_byte_n` low. Each driven lane carries the stored byte.
- R4: With `chip_sel_n` low, `wr_strobe_n` low and at least one lane enable low, the mode is write (`bus_mode` = 3) whatever `out_en_n` is, and `dq_drive` is 00.
- R5: A write ends at the first sample that is no longer in write mode. This covers the strobe rising, the select rising, or both lane enables going high. The address, data and lane enables of the last write-mode sample are then stored. Only the enabled lanes change, and the other lane keeps its old byte.
- R6: A pin state present at a rising clock edge appears on `bus_mode`, `dq_drive` and `dq_out` after the third rising edge. A read sampled on the edge right after a write's last sample returns the old data. A read sampled one edge later returns the new data.
- R7: Addresses at or above DEPTH read as zero on the driven lanes, and writes to them leave the memory unchanged.
- R8: While `rst` is high, `bus_mode` is 0, `dq_drive` is 00 and `dq_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_sel_n | input | 1 | Active-low device select |
| wr_strobe_n | input | 1 | Active-low write strobe |
| out_en_n | input | 1 | Active-low output enable |
| hi_byte_n | input | 1 | Active-low enable for bits 15:8 |
| lo_byte_n | input | 1 | Active-low enable for bits 7:0 |
| addr_pin | input | ADDR_W | Word address |
| dq_in | input | 16 | Data bus as received from the pads |
| dq_out | output | 16 | Data to place on the bus |
| dq_drive | output | 2 | Per-lane drive enable (bit 1 upper, bit 0 lower) |
| bus_mode | output | 2 | Decoded mode: 0 standby, 1 output-off, 2 read, 3 write |

## Verification
The bench targets writes ended by the select instead of the strobe. A design that only watched the strobe would lose those writes. It also runs single-lane writes followed by full-word reads. A design with shared lane gating would overwrite the untouched byte there. Other cases are a write with output enable held low, and both lane enables high while the chip is selected. In these a wrong mode priority would drive the bus during a write, or report output-off instead of standby. Finally, the bench reads an address right after writing it and probes the first out-of-range word. This exposes a design that commits on the wrong sample, or that wraps high addresses onto low ones.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;
  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_OUT_OFF = 2'd1,
    MODE_READ    = 2'd2,
    MODE_WRITE   = 2'd3
  } bus_mode_e;

  localparam int LANES  = 2;
  localparam int LANE_W = 8;
endpackage

// File: rtl/sram_emu_sync.sv
module sram_emu_sync #(
  parameter int              WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stab_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      stab_q <= RST_VAL;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/sram_emu_decode.sv
module sram_emu_decode
  import sram_emu_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int NLANE  = 2,
  parameter int LW     = 8,
  localparam int DW    = NLANE * LW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [NLANE-1:0]  be_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     data,
  output bus_mode_e         mode_now,
  output logic [NLANE-1:0]  lane_drive,
  output logic              commit,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [DW-1:0]     commit_data,
  output logic [NLANE-1:0]  commit_lanes
);
  logic no_lane;
  logic in_write;
  logic was_write_q;

  assign no_lane = &be_n;

  always_comb begin
    if (ce_n || no_lane)  mode_now = MODE_STANDBY;
    else if (!we_n)       mode_now = MODE_WRITE;
    else if (!oe_n)       mode_now = MODE_READ;
    else                  mode_now = MODE_OUT_OFF;
  end

  assign in_write   = (mode_now == MODE_WRITE);
  assign lane_drive = (mode_now == MODE_READ) ? ~be_n : '0;

  // Hold the last sample seen inside the write; it is what gets stored.
  always_ff @(posedge clk) begin
    if (rst) begin
      was_write_q  <= 1'b0;
      commit_addr  <= '0;
      commit_data  <= '0;
      commit_lanes <= '0;
    end else begin
      was_write_q <= in_write;
      if (in_write) begin
        commit_addr  <= addr;
        commit_data  <= data;
        commit_lanes <= ~be_n;
      end
    end
  end

  assign commit = was_write_q && !in_write;

  AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    commit |=> !commit); // R5

  AST_COMMIT_HAS_LANE: assert property (@(posedge clk) disable iff (rst)
    commit |-> (commit_lanes != '0)); // R5
endmodule

// File: rtl/sram_emu_mem.sv
module sram_emu_mem #(
  parameter int ADDR_W = 18,
  parameter int DEPTH  = 1024,
  parameter int NLANE  = 2,
  parameter int LW     = 8,
  localparam int DW    = NLANE * LW,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [NLANE-1:0]  wr_lanes,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(DEPTH);

  logic             wr_ok;
  logic             rd_ok;
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] rd_idx;

  assign wr_ok  = ({1'b0, wr_addr} < LIMIT);
  assign rd_ok  = ({1'b0, rd_addr} < LIMIT);
  assign wr_idx = wr_addr[IDX_W-1:0];
  assign rd_idx = rd_addr[IDX_W-1:0];

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [LW-1:0] ram [DEPTH];
    logic [LW-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (wr_en && wr_ok && wr_lanes[g])
        ram[wr_idx] <= wr_data[g*LW +: LW];
    end

    always_ff @(posedge clk) begin
      if (rst)        rd_q <= '0;
      else if (rd_ok) rd_q <= ram[rd_idx];
      else            rd_q <= '0;
    end

    assign rd_data[g*LW +: LW] = rd_q;
  end

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rd_ok |=> (rd_data == '0)); // R7
endmodule

// File: rtl/sram_pin_target.sv
module sram_pin_target
  import sram_emu_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DEPTH  = 1024,
  localparam int DW    = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chip_sel_n,
  input  logic              wr_strobe_n,
  input  logic              out_en_n,
  input  logic              hi_byte_n,
  input  logic              lo_byte_n,
  input  logic [ADDR_W-1:0] addr_pin,
  input  logic [DW-1:0]     dq_in,
  output logic [DW-1:0]     dq_out,
  output logic [LANES-1:0]  dq_drive,
  output logic [1:0]        bus_mode
);
  localparam int CTL_W = 3 + LANES;

  logic [CTL_W-1:0]  ctl_raw, ctl_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DW-1:0]     data_s;

  assign ctl_raw = {chip_sel_n, wr_strobe_n, out_en_n, hi_byte_n, lo_byte_n};

  sram_emu_sync #(.WIDTH(CTL_W), .RST_VAL({CTL_W{1'b1}})) u_sync_ctl (
    .clk(clk), .rst(rst), .d(ctl_raw), .q(ctl_s));
  sram_emu_sync #(.WIDTH(ADDR_W), .RST_VAL('0)) u_sync_addr (
    .clk(clk), .rst(rst), .d(addr_pin), .q(addr_s));
  sram_emu_sync #(.WIDTH(DW), .RST_VAL('0)) u_sync_data (
    .clk(clk), .rst(rst), .d(dq_in), .q(data_s));

  bus_mode_e         mode_now;
  logic [LANES-1:0]  lane_drive;
  logic              commit;
  logic [ADDR_W-1:0] commit_addr;
  logic [DW-1:0]     commit_data;
  logic [LANES-1:0]  commit_lanes;

  sram_emu_decode #(.ADDR_W(ADDR_W), .NLANE(LANES), .LW(LANE_W)) u_decode (
    .clk(clk), .rst(rst),
    .ce_n(ctl_s[CTL_W-1]), .we_n(ctl_s[CTL_W-2]), .oe_n(ctl_s[CTL_W-3]),
    .be_n(ctl_s[LANES-1:0]), .addr(addr_s), .data(data_s),
    .mode_now(mode_now), .lane_drive(lane_drive),
    .commit(commit), .commit_addr(commit_addr),
    .commit_data(commit_data), .commit_lanes(commit_lanes));

  sram_emu_mem #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .NLANE(LANES), .LW(LANE_W)) u_mem (
    .clk(clk), .rst(rst),
    .wr_en(commit), .wr_addr(commit_addr), .wr_data(commit_data),
    .wr_lanes(commit_lanes), .rd_addr(addr_s), .rd_data(dq_out));

  bus_mode_e        mode_q;
  logic [LANES-1:0] drive_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_STANDBY;
      drive_q <= '0;
    end else begin
      mode_q  <= mode_now;
      drive_q <= lane_drive;
    end
  end

  assign bus_mode = mode_q;
  assign dq_drive = drive_q;

  AST_STANDBY_FLOAT: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_STANDBY) |-> (drive_q == '0)); // R1
  AST_OUT_OFF_FLOAT: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_OUT_OFF) |-> (drive_q == '0)); // R2
  AST_DRIVE_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
    (drive_q != '0) |-> (mode_q == MODE_READ)); // R3
  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_WRITE) |-> (drive_q == '0)); // R4
  AST_COMMIT_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    commit |-> (mode_q == MODE_WRITE)); // R5
endmodule

// File: tb/sram_pin_target_tb.sv
`timescale 1ns/1ps
module sram_pin_target_tb_top;
  localparam int ADDR_W = 18;
  localparam int DEPTH  = 1024;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, ub_n = 1'b1, lb_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0]       din = '0;
  logic [15:0]       dout;
  logic [1:0]        drv;
  logic [1:0]        mode;

  always #4 clk = ~clk;

  sram_pin_target #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .chip_sel_n(ce_n), .wr_strobe_n(we_n),
    .out_en_n(oe_n), .hi_byte_n(ub_n), .lo_byte_n(lb_n),
    .addr_pin(addr), .dq_in(din), .dq_out(dout), .dq_drive(drv), .bus_mode(mode));

  int tests = 0;
  int fails = 0;
  bit running = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model
  typedef struct {
    logic [1:0]  mode;
    logic [1:0]  drv;
    logic [15:0] data;
    logic [1:0]  known;
    bit          oor;
  } exp_t;

  exp_t        q[$];
  logic [7:0]  mem_lo[int];
  logic [7:0]  mem_hi[int];
  bit          prev_w = 0;
  int          lat_a = 0;
  logic [15:0] lat_d = '0;
  logic [1:0]  lat_be = 2'b11;

  function automatic exp_t idle_exp();
    exp_t e;
    e.mode = 2'd0; e.drv = 2'b00; e.data = '0; e.known = 2'b00; e.oor = 0;
    return e;
  endfunction

  initial begin
    q.push_back(idle_exp());
    q.push_back(idle_exp());
  end

  always @(posedge clk) begin
    if (running) begin
      exp_t e;
      bit   cur_w;
      int   a;
      a = int'(addr);
      e = idle_exp();
      if (ce_n || (ub_n && lb_n)) e.mode = 2'd0;
      else if (!we_n)             e.mode = 2'd3;
      else if (!oe_n)             e.mode = 2'd2;
      else                        e.mode = 2'd1;
      if (e.mode == 2'd2) e.drv = {~ub_n, ~lb_n};
      e.oor = (a >= DEPTH);
      if (!e.oor) begin
        if (mem_lo.exists(a)) begin e.data[7:0]  = mem_lo[a]; e.known[0] = 1; end
        if (mem_hi.exists(a)) begin e.data[15:8] = mem_hi[a]; e.known[1] = 1; end
      end
      cur_w = (e.mode == 2'd3);
      if (prev_w && !cur_w && lat_a < DEPTH) begin
        if (!lat_be[0]) mem_lo[lat_a] = lat_d[7:0];
        if (!lat_be[1]) mem_hi[lat_a] = lat_d[15:8];
      end
      if (cur_w) begin
        lat_a = a; lat_d = din; lat_be = {ub_n, lb_n};
      end
      prev_w = cur_w;
      q.push_back(e);
    end
  end

  always @(negedge clk) begin
    if (running && q.size() >= 3) begin
      exp_t e;
      string tag;
      e = q.pop_front();
      check(mode == e.mode, "R6 mode code", mode, e.mode);
      case (e.mode)
        2'd0: tag = "R1 lane drive";
        2'd1: tag = "R2 lane drive";
        2'd2: tag = "R3 lane drive";
        default: tag = "R4 lane drive";
      endcase
      check(drv == e.drv, tag, drv, e.drv);
      for (int l = 0; l < 2; l++) begin
        if (e.drv[l]) begin
          if (e.oor)
            check(dout[l*8 +: 8] == 8'h00, "R7 out-of-range read", dout[l*8 +: 8], 0);
          else if (e.known[l])
            check(dout[l*8 +: 8] == e.data[l*8 +: 8], "R5 stored byte",
                  dout[l*8 +: 8], e.data[l*8 +: 8]);
        end
      end
    end
  end

  task automatic drive(input logic c, input logic w, input logic o, input logic u,
                       input logic b, input int a, input logic [15:0] d, input int n);
    ce_n = c; we_n = w; oe_n = o; ub_n = u; lb_n = b;
    addr = ADDR_W'(a); din = d;
    repeat (n) @(negedge clk);
  endtask

  task automatic idle(input int n);
    drive(1, 1, 1, 1, 1, 0, 16'h0, n);
  endtask

  task automatic wr(input int a, input logic [15:0] d, input logic u, input logic b,
                    input bit by_ce, input logic o);
    drive(0, 0, o, u, b, a, d, 3);
    if (by_ce) drive(1, 0, o, u, b, a, d, 1);
    else       drive(0, 1, 1, u, b, a, d, 1);
    idle(2);
  endtask

  task automatic rd(input int a, input logic u, input logic b);
    drive(0, 1, 0, u, b, a, 16'hDEAD, 4);
    idle(1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    check(mode == 2'd0, "R8 reset mode", mode, 0);
    check(drv == 2'b00, "R8 reset drive", drv, 0);
    check(dout == 16'h0, "R8 reset data", dout, 0);
    rst = 0;
    running = 1;
    idle(3);
    wr(5, 16'h1234, 0, 0, 0, 1);            // R5 full word, strobe ends
    rd(5, 0, 0);                            // R3
    wr(5, 16'hAB99, 0, 1, 1, 1);            // R5 upper only, select ends
    rd(5, 0, 0);
    rd(5, 1, 0);                            // R3 lower lane only
    rd(5, 0, 1);                            // R3 upper lane only
    drive(0, 1, 1, 0, 0, 5, 16'h0, 4);      // R2 output-off
    drive(0, 1, 0, 1, 1, 5, 16'h0, 4);      // R1 both lanes off
    wr(9, 16'h5A5A, 0, 0, 0, 0);            // R4 output enable low during write
    rd(9, 0, 0);
    wr(DEPTH - 1, 16'hC3C3, 0, 0, 0, 1);
    rd(DEPTH - 1, 0, 0);
    wr(DEPTH, 16'hFFFF, 0, 0, 0, 1);        // R7 write ignored
    rd(DEPTH, 0, 0);                        // R7 read zero
    rd(0, 0, 0);
    // R6: read immediately after the last write sample
    drive(0, 0, 1, 0, 0, 5, 16'h7E81, 3);
    drive(0, 1, 0, 0, 0, 5, 16'h0, 4);
    idle(2);
    begin
      logic [15:0] lf = 16'hACE1;
      for (int i = 0; i < 300; i++) begin
        int a;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        a = lf[3] ? (DEPTH - 4 + int'(lf[2:0])) : int'(lf[2:0]);
        case (lf[6:4])
          3'd0, 3'd1: wr(a, lf ^ 16'h3C5A, lf[7], lf[8] & ~lf[7], lf[9], lf[10]);
          3'd2, 3'd3, 3'd4: rd(a, lf[7], lf[8] & ~lf[7]);
          3'd5: drive(0, 1, 1, lf[7], lf[8], a, lf, 2);
          default: drive(lf[7], lf[8], lf[9], lf[10], lf[11], a, lf, 1);
        endcase
      end
    end
    idle(6);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule